// File: doc/BRIEF.md
# Letterboxed Raster Timing Generator

This block produces the scan timing for a 1280x768 display raster refreshed at 60 Hz from a pixel clock near 79.5 MHz: horizontal sync, vertical sync, a display-enable strobe and a frame-start marker. Each line lasts 1664 clocks, of which 1280 are visible. Each frame lasts 798 lines, of which 768 are visible. A 1280x720 picture sits in the vertical middle of the visible area. The 24 visible lines above it and the 24 below it are painted black.

Picture pixels come from a read FIFO as 16-bit RGB565 words, one word per request. The block raises `pixel_req` in the cycle before each picture pixel and expects the word on `pix_data` in the next cycle. This interface has no back-pressure. The block never waits for the FIFO, so the source must have a word ready in the cycle after every request. No requests are issued on the black letterbox lines or during blanking.

Words are widened to 8 bits per colour and sent out alongside the syncs. Every timing count, pulse width, porch length, window position and sync polarity is a parameter.

Top module: `letterbox_timing_gen`

## Requirements
- R1: Each line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks. `video_de` is high only in the first H_ACTIVE clocks of a line, and only on visible lines.
- R2: Each frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines. Lines 0 to V_ACTIVE-1 of the frame are the visible lines.
- R3: The horizontal sync is active from clock H_ACTIVE+H_FRONT of every line for H_SYNC clocks. Its active level is high when HS_ACTIVE_HIGH=1 and low when HS_ACTIVE_HIGH=0.
- R4: The vertical sync is active for whole lines, from line V_ACTIVE+V_FRONT for V_SYNC lines. Its active level is high when VS_ACTIVE_HIGH=1 and low when VS_ACTIVE_HIGH=0.
- R5: Visible lines IMG_TOP to IMG_TOP+IMG_LINES-1 carry the picture. On the other visible lines `rgb888` is 0 while `video_de` is high. Outside `video_de`, `rgb888` is always 0.
- R6: `pixel_req` is high exactly one cycle before each picture pixel appears with `video_de`. It is never high on black lines or in blanking. It is high exactly H_ACTIVE*IMG_LINES times per frame.
- R7: A picture pixel is shown on `rgb888` as {R8,G8,B8}, with R5 in bits 15:11, G6 in bits 10:5 and B5 in bits 4:0 of `pix_data`. The widening rules are R8={R5,R5[4:2]}, G8={G6,G6[5:4]} and B8={B5,B5[4:2]}.
- R8: `frame_start` is a one-cycle pulse, high together with the first `video_de` clock of visible line 0 of each frame.
- R9: While `rst_n` is low, the outputs hold these values: `video_de`, `pixel_req`, `frame_start` and `rgb888` are 0, and both syncs are at their inactive levels.
- R10: `pix_data` has no effect on `rgb888` in any cycle that does not follow a cycle with `pixel_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixel_req | output | 1 | Read strobe to the pixel FIFO; the word is due on the next cycle |
| pix_data | input | 16 | RGB565 word from the FIFO |
| video_de | output | 1 | Display enable (visible area) |
| hsync | output | 1 | Horizontal sync, polarity set by HS_ACTIVE_HIGH |
| vsync | output | 1 | Vertical sync, polarity set by VS_ACTIVE_HIGH |
| frame_start | output | 1 | One-cycle marker at the first visible pixel of a frame |
| rgb888 | output | 24 | Widened colour {R,G,B} |

## Verification
The assertions check these relations on every cycle:
- every request is followed by display enable;
- colour is zero outside display enable;
- neither sync is active while display enable is high;
- the frame marker is a single cycle that sits inside display enable.

Some behaviours can only be shown by the bench's sweeps over a reduced raster:
- the exact clock and line positions of the sync pulses;
- the placement of the letterbox window;
- the number of fetches in each frame;
- the bit-exact widening of each fetched word;
- the black lines ignoring whatever the FIFO bus carries.

// File: rtl/letterbox_pkg.sv
package letterbox_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb888_t;

endpackage

// File: rtl/lb_span_counter.sv
module lb_span_counter #(
  parameter int TOTAL = 1664,
  parameter int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         at_end
);
  localparam logic [W-1:0] LAST = W'(TOTAL - 1);

  assign at_end = (count == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= at_end ? '0 : count + 1'b1;
  end

  // R1 / R2: the position never leaves the span
  assert_in_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LAST);
endmodule

// File: rtl/lb_rgb_widen.sv
module lb_rgb_widen
  import letterbox_pkg::*;
(
  input  logic [15:0] word565,
  output rgb888_t     wide
);
  logic [4:0] r5;
  logic [5:0] g6;
  logic [4:0] b5;

  assign r5 = word565[15:11];
  assign g6 = word565[10:5];
  assign b5 = word565[4:0];

  // R7: each channel's top bits fill the low bits
  assign wide.r = {r5, r5[4:2]};
  assign wide.g = {g6, g6[5:4]};
  assign wide.b = {b5, b5[4:2]};
endmodule

// File: rtl/letterbox_timing_gen.sv
module letterbox_timing_gen
  import letterbox_pkg::*;
#(
  parameter int H_ACTIVE       = 1280,
  parameter int H_FRONT        = 64,
  parameter int H_SYNC         = 128,
  parameter int H_BACK         = 192,
  parameter int V_ACTIVE       = 768,
  parameter int V_FRONT        = 3,
  parameter int V_SYNC         = 7,
  parameter int V_BACK         = 20,
  parameter int IMG_TOP        = 24,
  parameter int IMG_LINES      = 720,
  parameter bit HS_ACTIVE_HIGH = 1'b0,
  parameter bit VS_ACTIVE_HIGH = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        pixel_req,
  input  logic [15:0] pix_data,
  output logic        video_de,
  output logic        hsync,
  output logic        vsync,
  output logic        frame_start,
  output logic [23:0] rgb888
);
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  localparam logic [HW-1:0] H_ACT_L = HW'(H_ACTIVE);
  localparam logic [HW-1:0] HS_BEG  = HW'(H_ACTIVE + H_FRONT);
  localparam logic [HW-1:0] HS_END  = HW'(H_ACTIVE + H_FRONT + H_SYNC);
  localparam logic [VW-1:0] V_ACT_L = VW'(V_ACTIVE);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_ACTIVE + V_FRONT);
  localparam logic [VW-1:0] VS_END  = VW'(V_ACTIVE + V_FRONT + V_SYNC);
  localparam logic [VW-1:0] IMG_BEG = VW'(IMG_TOP);
  localparam logic [VW-1:0] IMG_END = VW'(IMG_TOP + IMG_LINES);

  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic          h_wrap;
  logic          v_wrap;

  lb_span_counter #(.TOTAL(H_TOTAL), .W(HW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .step(1'b1), .count(h_pos), .at_end(h_wrap));

  lb_span_counter #(.TOTAL(V_TOTAL), .W(VW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .step(h_wrap), .count(v_pos), .at_end(v_wrap));

  // Decode of the current raster position
  logic h_vis, v_vis, img_row, hs_on, vs_on, first_px;
  assign h_vis    = (h_pos < H_ACT_L);
  assign v_vis    = (v_pos < V_ACT_L);
  assign img_row  = (v_pos >= IMG_BEG) && (v_pos < IMG_END);
  assign hs_on    = (h_pos >= HS_BEG) && (h_pos < HS_END);
  assign vs_on    = (v_pos >= VS_BEG) && (v_pos < VS_END);
  assign first_px = (h_pos == '0) && (v_pos == '0);

  // Fetch is issued one cycle ahead of the registered display stage
  assign pixel_req = h_vis && img_row;

  logic de_q, img_q, hs_q, vs_q, fs_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_q  <= 1'b0;
      img_q <= 1'b0;
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      de_q  <= h_vis && v_vis;
      img_q <= pixel_req;
      hs_q  <= hs_on;
      vs_q  <= vs_on;
      fs_q  <= first_px;
    end
  end

  rgb888_t wide;
  lb_rgb_widen u_widen (.word565(pix_data), .wide(wide));

  assign video_de    = de_q;
  assign frame_start = fs_q;
  assign hsync       = HS_ACTIVE_HIGH ? hs_q : ~hs_q;
  assign vsync       = VS_ACTIVE_HIGH ? vs_q : ~vs_q;
  assign rgb888      = img_q ? wide : 24'h0;

  // Assertions
  assert_req_then_de_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_req |=> video_de);
  assert_black_outside_de_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !video_de |-> (rgb888 == 24'h0));
  assert_hs_idle_in_de_R3: assert property (@(posedge clk) disable iff (!rst_n)
    video_de |-> (hsync == !HS_ACTIVE_HIGH));
  assert_vs_idle_in_de_R4: assert property (@(posedge clk) disable iff (!rst_n)
    video_de |-> (vsync == !VS_ACTIVE_HIGH));
  assert_fs_in_de_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> video_de);
  assert_fs_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (v_wrap && h_wrap) |=> (v_pos == '0));
endmodule

// File: tb/letterbox_timing_gen_tb.sv
module letterbox_timing_gen_tb;
  localparam int HA = 8, HF = 2, HS = 3, HB = 2;
  localparam int VA = 6, VF = 1, VS = 2, VB = 1;
  localparam int IT = 1, IL = 4;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FRAMES = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pix_data = 16'hFFFF;
  logic        pixel_req, video_de, hsync, vsync, frame_start;
  logic [23:0] rgb888;

  int tests = 0;
  int fails = 0;
  int n = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) n <= n + 1;

  letterbox_timing_gen #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .IMG_TOP(IT), .IMG_LINES(IL),
    .HS_ACTIVE_HIGH(1'b0), .VS_ACTIVE_HIGH(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pixel_req(pixel_req), .pix_data(pix_data),
    .video_de(video_de), .hsync(hsync), .vsync(vsync),
    .frame_start(frame_start), .rgb888(rgb888));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at n=%0d: actual %0h expected %0h", req, what, n, act, exp);
    end
  endtask

  function automatic logic [23:0] widen(input logic [15:0] w);
    int r, g, b;
    r = int'(w) / 2048;
    g = (int'(w) / 32) % 64;
    b = int'(w) % 32;
    return 24'((r * 8 + r / 4) * 65536 + (g * 4 + g / 16) * 256 + (b * 8 + b / 4));
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] exp_rgb;
    int fetches;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(video_de == 0 && pixel_req == 0 && frame_start == 0, "R9", "strobes",
          {video_de, pixel_req, frame_start}, 0);
    check(hsync == 1 && vsync == 0, "R9", "sync idle", {hsync, vsync}, 2'b10);
    check(rgb888 == 0, "R9", "rgb", rgb888, 0);
    rst_n = 1'b1;
    exp_rgb = 24'h0;
    fetches = 0;
    for (int k = 0; k < FRAMES * HT * VT; k++) begin
      int ho, vo, hp, vp;
      bit e_de, e_img, e_hs, e_vs, e_fs, e_req;
      @(negedge clk);
      ho = (n - 1) % HT;  vo = ((n - 1) / HT) % VT;
      hp = n % HT;        vp = (n / HT) % VT;
      e_de  = (ho < HA) && (vo < VA);
      e_img = e_de && (vo >= IT) && (vo < IT + IL);
      e_hs  = (ho >= HA + HF) && (ho < HA + HF + HS);
      e_vs  = (vo >= VA + VF) && (vo < VA + VF + VS);
      e_fs  = (ho == 0) && (vo == 0);
      e_req = (hp < HA) && (vp >= IT) && (vp < IT + IL);
      check(video_de == e_de, (vo < VA) ? "R1" : "R2", "video_de", video_de, e_de);
      check(hsync == !e_hs, "R3", "hsync", hsync, !e_hs);
      check(vsync == e_vs, "R4", "vsync", vsync, e_vs);
      check(frame_start == e_fs, "R8", "frame_start", frame_start, e_fs);
      check(pixel_req == e_req, "R6", "pixel_req", pixel_req, e_req);
      if (e_img)
        check(rgb888 == exp_rgb, "R7", "widened pixel", rgb888, exp_rgb);
      else
        check(rgb888 == 0, e_de ? "R5" : "R10", "black rgb", rgb888, 0);
      if (pixel_req) fetches++;
      if (hp == 0 && vp == 0) begin
        // R6: a frame just ended at position n
        check(fetches == HA * IL, "R6", "fetches per frame", fetches, HA * IL);
        fetches = 0;
      end
      // drive the FIFO word; junk when nothing was requested (R10)
      if (pixel_req) begin
        pix_data = 16'((k * 40503 + 7) ^ (k << 5));
        exp_rgb  = widen(pix_data);
      end else begin
        pix_data = 16'hFFFF;
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule